// File: doc/BRIEF.md
# Punctured-Code Symbol Depuncturer

This block sits between a soft-decision demodulator and a rate-1/2 Viterbi decoder. It accepts the received stream of soft symbols, one transmitted symbol per handshake beat, and rebuilds the full stream of G1/G2 symbol pairs that the mother code produced before puncturing. Wherever the transmitter deleted a symbol, the block fills the slot with a mid-scale soft value and raises a per-lane erasure flag, so the decoder gives that position no weight.

A rate selector chooses among fixed deletion patterns for rates 2/3, 3/4 and 7/8. It also offers a plain rate-1/2 pass-through and an external mode. In external mode the caller supplies a G1/G2 keep mask for each column, which covers other punctured rates such as 5/6 and 6/7. A sync pulse restarts the pattern on the next accepted symbol. A phase-offset input selects which column of the pattern that symbol belongs to, so an outside alignment search can try each phase in turn.

Input and output both use valid/ready handshakes. An output pair that is waiting stalls the input, so back-pressure passes straight through the block.

Top module: `sym_depuncturer`

## Requirements
- R1: After reset `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: With `rate_i` = 0, and also for the unused codes 5, 6 and 7, every two accepted symbols form one output pair. The first symbol goes to G1 and the second to G2, and neither erasure flag is set.
- R3: With `rate_i` = 1 the pattern has period 2. Column 0 carries G1 and G2. Column 1 carries G2 only, so G1 is erased.
- R4: With `rate_i` = 2 the pattern has period 3. Column 0 carries both symbols. Column 1 carries G2 only. Column 2 carries G1 only.
- R5: With `rate_i` = 3 the pattern has period 7. Columns 0 to 3 carry both symbols except columns 1, 2 and 3, where G1 is erased. Column 4 carries G1 only, column 5 carries G2 only, and column 6 carries G1 only.
- R6: With `rate_i` = 4, `ext_keep_i` is sampled together with the first symbol of each column. Bit 0 set means G1 was sent and bit 1 set means G2 was sent. The value 0 is treated as 3.
- R7: An erased slot outputs the value 2^(SYM_W-1) with its erasure flag set to 1. A slot that was sent outputs the received symbol with its flag set to 0.
- R8: After a pulse on `sync_i`, the next accepted symbol is the first sent symbol of column (`phase_off_i` mod period). A half-built pair is discarded. A pulse that arrives while no symbol is being accepted stays pending until one is.
- R9: A pair on the output holds its value while `out_ready_i` is low. `in_ready_o` is high only when the output register is empty or is being emptied in that cycle. No pair is lost, duplicated or reordered.
- R10: After the last column of a pattern, the column index wraps to 0 and the pattern continues without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_i | input | 3 | Pattern select: 0 = 1/2, 1 = 2/3, 2 = 3/4, 3 = 7/8, 4 = external, 5 to 7 = 1/2 |
| phase_off_i | input | 3 | Starting column applied at a sync |
| sync_i | input | 1 | Pattern restart pulse |
| ext_keep_i | input | 2 | External column keep mask (bit 0 G1, bit 1 G2) |
| in_valid_i | input | 1 | Input symbol valid |
| in_ready_o | output | 1 | Input symbol accepted when high with valid |
| in_sym_i | input | SYM_W | Received soft symbol |
| out_valid_o | output | 1 | Output pair valid |
| out_ready_i | input | 1 | Downstream accepts the pair |
| out_g1_o | output | SYM_W | G1 soft value |
| out_g2_o | output | SYM_W | G2 soft value |
| out_g1_erased_o | output | 1 | G1 slot was deleted |
| out_g2_erased_o | output | 1 | G2 slot was deleted |

## Verification
The bench uses the default SYM_W of 3, so the erasure value is 4 and every one of the eight soft codes appears as random data that can be told apart from a fill. The pattern period is at most 7 and the phase offset is 3 bits wide, so random offsets from 0 to 7 reach every fold of the offset modulo each period. That includes offsets larger than the period, and the period-1 modes where every offset folds to 0. Random input gaps and random downstream stalls cover both the pending-sync path and the held-output path.

// File: rtl/dpn_pkg.sv
package dpn_pkg;
  localparam int MAX_COLS = 7;
  localparam int COL_W    = $clog2(MAX_COLS + 1);
  localparam int MASK_W   = 1 << COL_W;

  typedef logic [COL_W-1:0]  col_t;
  typedef logic [MASK_W-1:0] mask_t;

  typedef enum logic [2:0] {
    RT_HALF = 3'd0,
    RT_2_3  = 3'd1,
    RT_3_4  = 3'd2,
    RT_7_8  = 3'd3,
    RT_EXT  = 3'd4
  } rate_e;

  // number of columns in one pattern period
  function automatic col_t pattern_period(rate_e r);
    case (r)
      RT_2_3:  return col_t'(2);
      RT_3_4:  return col_t'(3);
      RT_7_8:  return col_t'(7);
      default: return col_t'(1);
    endcase
  endfunction

  // bit c set = G1 sent in column c
  function automatic mask_t g1_sent(rate_e r);
    case (r)
      RT_2_3:  return mask_t'(8'b0000_0001);
      RT_3_4:  return mask_t'(8'b0000_0101);
      RT_7_8:  return mask_t'(8'b0101_0001);
      default: return mask_t'(8'b0000_0001);
    endcase
  endfunction

  // bit c set = G2 sent in column c
  function automatic mask_t g2_sent(rate_e r);
    case (r)
      RT_2_3:  return mask_t'(8'b0000_0011);
      RT_3_4:  return mask_t'(8'b0000_0011);
      RT_7_8:  return mask_t'(8'b0010_1111);
      default: return mask_t'(8'b0000_0001);
    endcase
  endfunction

  // offset reduced modulo the period by repeated subtraction
  function automatic col_t fold_offset(col_t off, col_t len);
    col_t v;
    v = off;
    for (int i = 0; i < MAX_COLS; i++) begin
      if (v >= len) v = v - len;
    end
    return v;
  endfunction

  function automatic col_t next_col(col_t c, col_t len);
    logic [COL_W:0] n;
    n = {1'b0, c} + (COL_W + 1)'(1);
    return (n >= {1'b0, len}) ? '0 : n[COL_W-1:0];
  endfunction
endpackage

// File: rtl/dpn_pattern.sv
module dpn_pattern
  import dpn_pkg::*;
(
  input  rate_e      rate_i,
  input  col_t       col_i,
  input  logic [1:0] ext_keep_i,
  output logic       keep_g1_o,
  output logic       keep_g2_o
);
  mask_t m1, m2;

  always_comb begin
    m1 = g1_sent(rate_i);
    m2 = g2_sent(rate_i);
    if (rate_i == RT_EXT) begin
      keep_g1_o = ext_keep_i[0] | (ext_keep_i == 2'b00);
      keep_g2_o = ext_keep_i[1] | (ext_keep_i == 2'b00);
    end else begin
      keep_g1_o = m1[col_i];
      keep_g2_o = m2[col_i];
    end
  end
endmodule

// File: rtl/dpn_phase.sv
module dpn_phase
  import dpn_pkg::*;
#(
  parameter int SYM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic             sync_i,
  input  col_t             off_i,
  input  col_t             len_i,
  input  logic             take_i,
  input  logic             pair_done_i,
  input  logic [SYM_W-1:0] sym_i,
  output col_t             cur_col_o,
  output logic             cur_half_o,
  output logic [SYM_W-1:0] held_g1_o
);
  col_t col_q;
  logic half_q;
  logic sync_pend_q;
  logic sync_now;
  col_t base_col;

  assign sync_now   = (sync_pend_q | sync_i) & in_valid_i;
  assign base_col   = (col_q >= len_i) ? '0 : col_q;
  assign cur_col_o  = sync_now ? fold_offset(off_i, len_i) : base_col;
  assign cur_half_o = sync_now ? 1'b0 : half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q       <= '0;
      half_q      <= 1'b0;
      held_g1_o   <= '0;
      sync_pend_q <= 1'b0;
    end else begin
      if (take_i) begin
        if (pair_done_i) begin
          half_q <= 1'b0;
          col_q  <= next_col(cur_col_o, len_i);
        end else begin
          half_q    <= 1'b1;
          col_q     <= cur_col_o;
          held_g1_o <= sym_i;
        end
      end
      if (take_i && sync_now) sync_pend_q <= 1'b0;
      else if (sync_i)        sync_pend_q <= 1'b1;
    end
  end

  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    col_q < col_t'(MAX_COLS)); // R10
  AST_HALF_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_q) |-> $past(take_i)); // R2
endmodule

// File: rtl/dpn_outreg.sv
module dpn_outreg #(
  parameter int SYM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SYM_W-1:0] g1_i,
  input  logic [SYM_W-1:0] g2_i,
  input  logic             e1_i,
  input  logic             e2_i,
  input  logic             ready_i,
  output logic             space_o,
  output logic             valid_o,
  output logic [SYM_W-1:0] g1_o,
  output logic [SYM_W-1:0] g2_o,
  output logic             e1_o,
  output logic             e2_o
);
  localparam logic [SYM_W-1:0] MID = {1'b1, {(SYM_W-1){1'b0}}};

  assign space_o = ~valid_o | ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      g1_o    <= '0;
      g2_o    <= '0;
      e1_o    <= 1'b0;
      e2_o    <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      g1_o    <= g1_i;
      g2_o    <= g2_i;
      e1_o    <= e1_i;
      e2_o    <= e2_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable({g1_o, g2_o, e1_o, e2_o})); // R9
  AST_ERASE_MID_G1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && e1_o |-> g1_o == MID); // R7
  AST_ERASE_MID_G2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && e2_o |-> g2_o == MID); // R7
  AST_LOAD_WITH_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> space_o); // R9
endmodule

// File: rtl/sym_depuncturer.sv
module sym_depuncturer
  import dpn_pkg::*;
#(
  parameter int SYM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rate_i,
  input  logic [2:0]       phase_off_i,
  input  logic             sync_i,
  input  logic [1:0]       ext_keep_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [SYM_W-1:0] in_sym_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [SYM_W-1:0] out_g1_o,
  output logic [SYM_W-1:0] out_g2_o,
  output logic             out_g1_erased_o,
  output logic             out_g2_erased_o
);
  localparam logic [SYM_W-1:0] ERASE_VAL = {1'b1, {(SYM_W-1){1'b0}}};

  rate_e            rate;
  col_t             period;
  col_t             cur_col;
  logic             cur_half;
  logic [SYM_W-1:0] held_g1;
  logic             keep_g1, keep_g2;
  logic             space, take, emit;
  logic [SYM_W-1:0] pair_g1, pair_g2;
  logic             pair_e1, pair_e2;

  assign rate   = rate_e'(rate_i);
  assign period = (rate == RT_EXT) ? col_t'(1) : pattern_period(rate);

  assign in_ready_o = space;
  assign take       = in_valid_i & space;
  // a pair closes on the G2 slot, or at once when the column sends one symbol
  assign emit       = take & (cur_half | ~keep_g1 | ~keep_g2);

  always_comb begin
    pair_e1 = ~cur_half & ~keep_g1;
    pair_e2 = ~cur_half & ~keep_g2;
    pair_g1 = cur_half ? held_g1 : (keep_g1 ? in_sym_i : ERASE_VAL);
    pair_g2 = pair_e2 ? ERASE_VAL : in_sym_i;
  end

  dpn_pattern u_pattern (
    .rate_i     (rate),
    .col_i      (cur_col),
    .ext_keep_i (ext_keep_i),
    .keep_g1_o  (keep_g1),
    .keep_g2_o  (keep_g2)
  );

  dpn_phase #(.SYM_W(SYM_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .sync_i      (sync_i),
    .off_i       (col_t'(phase_off_i)),
    .len_i       (period),
    .take_i      (take),
    .pair_done_i (emit),
    .sym_i       (in_sym_i),
    .cur_col_o   (cur_col),
    .cur_half_o  (cur_half),
    .held_g1_o   (held_g1)
  );

  dpn_outreg #(.SYM_W(SYM_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (emit),
    .g1_i    (pair_g1),
    .g2_i    (pair_g2),
    .e1_i    (pair_e1),
    .e2_i    (pair_e2),
    .ready_i (out_ready_i),
    .space_o (space),
    .valid_o (out_valid_o),
    .g1_o    (out_g1_o),
    .g2_o    (out_g2_o),
    .e1_o    (out_g1_erased_o),
    .e2_o    (out_g2_erased_o)
  );

  AST_OUT_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(take)); // R9
  AST_HALF_RATE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    emit && rate == RT_HALF |-> !pair_e1 && !pair_e2); // R2
endmodule

// File: tb/sym_depuncturer_bench.sv
module sym_depuncturer_bench;
  localparam int SYM_W = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] rate_i = 0, phase_off_i = 0;
  logic sync_i = 0;
  logic [1:0] ext_keep_i = 0;
  logic in_valid_i = 0, in_ready_o;
  logic [SYM_W-1:0] in_sym_i = 0;
  logic out_valid_o, out_ready_i = 0;
  logic [SYM_W-1:0] out_g1_o, out_g2_o;
  logic out_g1_erased_o, out_g2_erased_o;

  int checks = 0, fails = 0;
  bit done = 0;

  int isym[$], ikeep[$], ifirst[$];
  int xg1[$], xg2[$], xe1[$], xe2[$];

  always #5 clk = ~clk;

  sym_depuncturer #(.SYM_W(SYM_W)) u_sym_depuncturer (.*);

  function automatic int b_len(int r);
    case (r)
      1: return 2;
      2: return 3;
      3: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic logic [1:0] b_keep(int r, int c);
    string s1, s2;
    case (r)
      1: begin s1 = "10"; s2 = "11"; end
      2: begin s1 = "101"; s2 = "110"; end
      3: begin s1 = "1000101"; s2 = "1111010"; end
      default: begin s1 = "1"; s2 = "1"; end
    endcase
    return {(s2[c] == "1"), (s1[c] == "1")};
  endfunction

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic build(input int r, input int ofs, input int ncols, input bit zero_first, input bit dangle);
    int len, c, raw;
    logic [1:0] eff;
    len = b_len(r);
    for (int k = 0; k < ncols; k++) begin
      int a, b;
      c = (ofs % len + k) % len;
      if (r == 4) begin
        raw = (zero_first && k == 0) ? 0 : int'($urandom % 4);
        eff = (raw == 0) ? 2'b11 : 2'(raw);
      end else begin
        eff = b_keep(r, c);
        raw = int'(eff);
      end
      a = int'($urandom % 8);
      b = int'($urandom % 8);
      if (eff[0]) begin isym.push_back(a); ikeep.push_back(raw); ifirst.push_back(1); end
      if (eff[1]) begin isym.push_back(b); ikeep.push_back(raw); ifirst.push_back(eff[0] ? 0 : 1); end
      xg1.push_back(eff[0] ? a : 4); xe1.push_back(eff[0] ? 0 : 1);
      xg2.push_back(eff[1] ? b : 4); xe2.push_back(eff[1] ? 0 : 1);
    end
    if (dangle) begin isym.push_back(7); ikeep.push_back(3); ifirst.push_back(1); end
  endtask

  task automatic run_test(input int r, input int ofs, input int ncols, input int sync_style,
                          input bit zero_first, input bit dangle, input string req);
    build(r, ofs, ncols, zero_first, dangle);
    @(negedge clk);
    rate_i = 3'(r);
    phase_off_i = 3'(ofs);
    if (sync_style == 1) begin
      sync_i = 1;
      @(negedge clk);
      sync_i = 0;
      @(negedge clk);
    end
    fork
      begin : drv
        bit first_beat = 1;
        while (isym.size() > 0) begin
          bit acc = 0;
          if ($urandom % 4 == 0) begin
            @(negedge clk);
            in_valid_i = 0;
            sync_i = 0;
          end
          while (!acc) begin
            @(negedge clk);
            in_valid_i = 1;
            in_sym_i = SYM_W'(isym[0]);
            ext_keep_i = 2'(ikeep[0]);
            sync_i = (sync_style == 0) && first_beat;
            first_beat = 0;
            #2;
            acc = in_ready_o;
            @(posedge clk);
          end
          void'(isym.pop_front()); void'(ikeep.pop_front()); void'(ifirst.pop_front());
        end
        @(negedge clk);
        in_valid_i = 0;
        sync_i = 0;
      end
      begin : mon
        int n, got;
        bit stalled;
        logic [SYM_W-1:0] sg1, sg2;
        n = xg1.size();
        got = 0;
        stalled = 0;
        while (got < n) begin
          @(negedge clk);
          out_ready_i = ($urandom % 4) != 0;
          #2;
          if (stalled) begin
            chk(out_valid_o && out_g1_o == sg1 && out_g2_o == sg2,
                {"R9 held pair stable ", req}, int'(out_g1_o), int'(sg1));
          end
          stalled = out_valid_o && !out_ready_i;
          sg1 = out_g1_o;
          sg2 = out_g2_o;
          if (out_valid_o && out_ready_i) begin
            bit er;
            er = (xe1[0] != 0) || (xe2[0] != 0);
            chk(int'(out_g1_o) == xg1[0] && int'(out_g1_erased_o) == xe1[0],
                {er ? "R7 " : "", req, " G1"}, int'(out_g1_o) * 2 + int'(out_g1_erased_o), xg1[0] * 2 + xe1[0]);
            chk(int'(out_g2_o) == xg2[0] && int'(out_g2_erased_o) == xe2[0],
                {er ? "R7 " : "", req, " G2"}, int'(out_g2_o) * 2 + int'(out_g2_erased_o), xg2[0] * 2 + xe2[0]);
            void'(xg1.pop_front()); void'(xg2.pop_front());
            void'(xe1.pop_front()); void'(xe2.pop_front());
            got++;
          end
        end
      end
    join
    @(negedge clk);
    out_ready_i = 1;
    begin
      bit extra = 0;
      for (int i = 0; i < 4; i++) begin
        #2;
        if (out_valid_o) extra = 1;
        @(negedge clk);
      end
      chk(!extra, {"R9 no extra pair ", req}, int'(extra), 0);
    end
    out_ready_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid_o == 0, "R1 out_valid after reset", int'(out_valid_o), 0);
    chk(in_ready_o == 1, "R1 in_ready after reset", int'(in_ready_o), 1);
    @(negedge clk);
    rst_n = 1;
    #2;
    chk(out_valid_o == 0 && in_ready_o == 1, "R1 idle after release", int'(out_valid_o), 0);

    run_test(0, 0, 6, 0, 0, 0, "R2 rate half");
    run_test(6, 3, 4, 1, 0, 0, "R2 unused code");
    run_test(1, 0, 6, 0, 0, 0, "R3 rate 2/3");
    run_test(2, 0, 7, 0, 0, 0, "R4 rate 3/4");
    run_test(3, 0, 16, 1, 0, 0, "R5 R10 rate 7/8 wrap");
    run_test(4, 0, 10, 0, 1, 0, "R6 external keep");
    run_test(1, 1, 5, 1, 0, 0, "R8 R3 offset one");
    run_test(2, 5, 5, 0, 0, 0, "R8 R4 offset folds");
    run_test(3, 6, 9, 1, 0, 0, "R8 R5 offset six");
    run_test(0, 0, 3, 0, 0, 1, "R8 dangling half");
    run_test(2, 1, 4, 1, 0, 0, "R8 resync drops half");
    for (int t = 0; t < 40; t++) begin
      int r;
      r = int'($urandom % 8);
      run_test(r, int'($urandom % 8), 1 + int'($urandom % 20), int'($urandom % 2),
               int'($urandom % 2) == 1, 0, "R9 R10 random mix");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule